// File: doc/BRIEF.md
# Burst Access Controller for a Pipelined Common-I/O SRAM

This controller sits between a simple request/ready host port and a pipelined synchronous SRAM that shares one data bus for reads and writes and needs no idle cycles between them. The host hands over a complete request in one handshake: start address, read or write, beat count (one to `MAX_BEATS`), and, for writes, a payload with per-beat byte enables. The controller then issues one address phase per clock. The first phase pulses the load strobe and the later phases hold it high so that the memory advances its own counter. The controller presents the write data, or takes in the read data, exactly two clocks after each address phase.

Alongside the control pins, the controller computes the address the memory's burst counter will reach on each beat. It follows either a linear or an interleaved order, chosen by a strap input, and wraps within an aligned group of four. A deadline timer tracks the time since the memory last saw four deselected clocks in a row. When the limit comes near, the controller stops accepting requests. As soon as the current burst ends, it inserts a forced deselect of four clocks. The output-enable and drive-enable outputs follow a two-stage phase pipeline, so the controller never drives the bus while read data is due. The bus is also quiet two clocks after any deselected cycle.

The state machine has three states. `ST_IDLE` keeps the memory deselected and raises ready. `ST_ACCESS` issues address phases. `ST_FORCE` holds a forced deselect and keeps ready low. The transitions are:
- *accept* (ST_IDLE to ST_ACCESS): valid and ready at the same edge.
- *burst end* (ST_ACCESS to ST_IDLE): the last beat completes and no deselect is due.
- *burst end, due* (ST_ACCESS to ST_FORCE): the last beat completes and a deselect is due.
- *due* (ST_IDLE to ST_FORCE): a deselect becomes due while no burst is running.
- *force done* (ST_FORCE to ST_IDLE): the fourth forced cycle completes.

Top module: `sram_burst_ctrl`

## Requirements
- R1: During and just after reset: `sram_ce_n`=1, `sram_ld_n`=0, `sram_oe_n`=1, `sram_dq_oe`=0, `rd_valid`=0 and `req_ready`=1.
- R2: A handshake (`req_valid` and `req_ready` high at a rising edge) starts a burst in the next cycle. The burst lasts `req_len`+1 consecutive cycles with `sram_ce_n`=0. `sram_ld_n` is 0 on the first beat and 1 on every later beat. `sram_we_n` is 0 for a write and 1 for a read. After the last beat, `sram_ce_n` returns to 1.
- R3: With `burst_mode`=0 (linear), beat k presents an address whose bits above bit 1 equal those of `req_addr`. Its two low bits are (`req_addr[1:0]` + k) mod 4.
- R4: With `burst_mode`=1 (interleaved), the two low bits of beat k are `req_addr[1:0]` XOR (k mod 4). The upper bits are unchanged.
- R5: A burst longer than four beats wraps: beat k (k ≥ 4) presents the same address as beat k−4.
- R6: On write beat k, `sram_bw_n` is the bitwise inverse of `req_be[k*NB +: NB]`, where bit j of `sram_bw_n` enables byte j (data bits 8j+7..8j) when low. On read beats `sram_bw_n` is all ones.
- R7: Two cycles after a write address phase, `sram_dq_oe`=1, `sram_oe_n`=1 and `sram_dq_out` equals `req_wdata[k*DW +: DW]` for that beat.
- R8: Two cycles after a read address phase, `sram_oe_n`=0 and `sram_dq_oe`=0. In the following cycle `rd_valid`=1 and `rd_data` holds the `sram_dq_in` value from that data cycle. Read beats return in issue order.
- R9: In any cycle two clocks after a cycle with `sram_ce_n`=1, `sram_dq_oe`=0 and `sram_oe_n`=1.
- R10: Whenever `sram_ce_n`=1, `sram_ld_n`=0.
- R11: Out of reset, no more than `DEADLINE` cycles ever pass without a cycle that ends a run of at least four consecutive deselected cycles.
- R12: A forced deselect never splits a burst. Whenever `req_ready` is low during a deselected stretch, that stretch lasts at least four cycles.
- R13: `burst_mode` must not change while reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| burst_mode | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Start word address |
| req_len | input | $clog2(MAX_BEATS) | Beat count minus one |
| req_wdata | input | MAX_BEATS*DW | Write payload, beat k in bits k*DW +: DW |
| req_be | input | MAX_BEATS*DW/8 | Byte enables, beat k in bits k*NB +: NB, active high |
| rd_valid | output | 1 | One read beat is available |
| rd_data | output | DW | Read beat data |
| sram_addr | output | AW | Address for the current beat |
| sram_ld_n | output | 1 | Load strobe, low loads, high advances |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_bw_n | output | DW/8 | Byte write enables, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | DW | Write data onto the shared bus |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_out` |
| sram_dq_in | input | DW | Data from the shared bus |

## Verification
The embedded assertions check several rules on every clock: write and read data phases land exactly two cycles after their address phases, the bus is quiet two clocks after each deselected cycle, bursts run unbroken, the deadline counter stays under its limit, a due deselect follows the final beat, and the strap stays still. Other behaviours can only be shown by the bench's scenarios against its behavioural model: the address order in both modes, the wrap past four beats, byte-masked writes read back through the memory model, in-order read data, and the cycle gap between completed deselects under saturating traffic and long idle.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    // Address phase to data phase distance, in clocks.
    localparam int PIPE_LAT = 2;
    // Consecutive deselected clocks the memory needs.
    localparam int DESEL_CYCLES = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FORCE  = 2'd2
    } ctrl_state_e;

    // Low two address bits for a given beat of a four-location group.
    function automatic logic [1:0] burst_low(
        input logic [1:0] start,
        input logic [1:0] idx,
        input logic       interleave
    );
        if (interleave) begin
            return start ^ idx;
        end
        return start + idx;
    endfunction

endpackage

// File: rtl/sbc_addr_seq.sv
module sbc_addr_seq #(
    parameter int AW = 21
) (
    input  logic [AW-1:0] base,
    input  logic [1:0]    beat,
    input  logic          interleave,
    output logic [AW-1:0] addr
);
    // Only the low pair of bits moves; beats past the fourth reuse beat mod 4.
    assign addr = {base[AW-1:2], sbc_pkg::burst_low(base[1:0], beat, interleave)};
endmodule

// File: rtl/sbc_deadline.sv
module sbc_deadline #(
    parameter int DEADLINE = 1600,
    parameter int GUARD    = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic desel,
    output logic due
);
    import sbc_pkg::*;

    localparam int CNTW = $clog2(DEADLINE + 1);
    localparam int RUNW = $clog2(DESEL_CYCLES + 1);

    logic [RUNW-1:0] run_q;
    logic [CNTW-1:0] cnt_q;
    logic            settled;

    // This cycle closes a run of at least DESEL_CYCLES deselected clocks.
    assign settled = desel && (run_q >= RUNW'(DESEL_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!desel) begin
            run_q <= '0;
        end else if (run_q != RUNW'(DESEL_CYCLES)) begin
            run_q <= run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (settled) begin
            cnt_q <= '0;
        end else if (cnt_q != CNTW'(DEADLINE)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign due = cnt_q >= CNTW'(DEADLINE - GUARD);

    // R11: the guard band keeps the count below the limit.
    a_r11_deadline_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNTW'(DEADLINE));

endmodule

// File: rtl/sbc_bus_pipe.sv
module sbc_bus_pipe #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ph_valid,
    input  logic          ph_write,
    input  logic [DW-1:0] ph_data,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          oe_n,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    import sbc_pkg::*;

    logic          st_v [PIPE_LAT];
    logic          st_w [PIPE_LAT];
    logic [DW-1:0] st_d [PIPE_LAT];

    for (genvar i = 0; i < PIPE_LAT; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_v[i] <= 1'b0;
                st_w[i] <= 1'b0;
                st_d[i] <= '0;
            end else if (i == 0) begin
                st_v[i] <= ph_valid;
                st_w[i] <= ph_write;
                st_d[i] <= ph_data;
            end else begin
                st_v[i] <= st_v[(i == 0) ? 0 : i-1];
                st_w[i] <= st_w[(i == 0) ? 0 : i-1];
                st_d[i] <= st_d[(i == 0) ? 0 : i-1];
            end
        end
    end

    logic wr_phase, rd_phase;
    assign wr_phase = st_v[PIPE_LAT-1] &&  st_w[PIPE_LAT-1];
    assign rd_phase = st_v[PIPE_LAT-1] && !st_w[PIPE_LAT-1];

    assign dq_out = st_d[PIPE_LAT-1];
    assign dq_oe  = wr_phase;
    assign oe_n   = !rd_phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_phase;
            if (rd_phase) begin
                rd_data <= dq_in;
            end
        end
    end

    // R7: write data is driven, outputs disabled, two clocks after its address.
    a_r7_write_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ph_valid && ph_write, 2) |-> (dq_oe && oe_n && dq_out == $past(ph_data, 2)));

    // R8: read phase enables the memory outputs and releases the bus.
    a_r8_read_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ph_valid && !ph_write, 2) |-> (!dq_oe && !oe_n));

    // R8: one captured beat per read phase.
    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ph_valid && !ph_write, 2) |=> rd_valid);

endmodule

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl #(
    parameter int AW        = 21,
    parameter int DW        = 32,
    parameter int MAX_BEATS = 8,
    parameter int DEADLINE  = 1600
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          burst_mode,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_write,
    input  logic [AW-1:0]                 req_addr,
    input  logic [$clog2(MAX_BEATS)-1:0]  req_len,
    input  logic [MAX_BEATS*DW-1:0]       req_wdata,
    input  logic [MAX_BEATS*(DW/8)-1:0]   req_be,
    output logic                          rd_valid,
    output logic [DW-1:0]                 rd_data,
    output logic [AW-1:0]                 sram_addr,
    output logic                          sram_ld_n,
    output logic                          sram_ce_n,
    output logic                          sram_we_n,
    output logic [DW/8-1:0]               sram_bw_n,
    output logic                          sram_oe_n,
    output logic [DW-1:0]                 sram_dq_out,
    output logic                          sram_dq_oe,
    input  logic [DW-1:0]                 sram_dq_in
);
    import sbc_pkg::*;

    localparam int NB    = DW / 8;
    localparam int CW    = $clog2(MAX_BEATS);
    // Longest burst plus forced deselect plus margin.
    localparam int GUARD = MAX_BEATS + DESEL_CYCLES + 2;

    ctrl_state_e state_q, state_d;

    logic [CW-1:0]           beat_q, len_q;
    logic [AW-1:0]           base_q;
    logic                    wr_q;
    logic [MAX_BEATS*DW-1:0] wdata_q;
    logic [MAX_BEATS*NB-1:0] be_q;
    logic [1:0]              fcnt_q;

    logic          due;
    logic          accept;
    logic          last_beat;
    logic [AW-1:0] seq_addr;
    logic          ph_valid;
    logic [DW-1:0] ph_data;

    assign accept    = (state_q == ST_IDLE) && !due && req_valid;
    assign last_beat = (state_q == ST_ACCESS) && (beat_q == len_q);

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (due) begin
                    state_d = ST_FORCE;
                end else if (req_valid) begin
                    state_d = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (beat_q == len_q) begin
                    state_d = due ? ST_FORCE : ST_IDLE;
                end
            end
            ST_FORCE: begin
                if (fcnt_q == 2'(DESEL_CYCLES - 1)) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request holding registers and beat / forced-deselect counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q  <= '0;
            len_q   <= '0;
            base_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            be_q    <= '0;
            fcnt_q  <= '0;
        end else begin
            if (accept) begin
                beat_q  <= '0;
                len_q   <= req_len;
                base_q  <= req_addr;
                wr_q    <= req_write;
                wdata_q <= req_wdata;
                be_q    <= req_be;
            end else if ((state_q == ST_ACCESS) && !last_beat) begin
                beat_q <= beat_q + 1'b1;
            end
            if (state_q == ST_FORCE) begin
                fcnt_q <= fcnt_q + 1'b1;
            end else begin
                fcnt_q <= '0;
            end
        end
    end

    sbc_addr_seq #(.AW(AW)) u_addr_seq (
        .base       (base_q),
        .beat       (beat_q[1:0]),
        .interleave (burst_mode),
        .addr       (seq_addr)
    );

    sbc_deadline #(.DEADLINE(DEADLINE), .GUARD(GUARD)) u_deadline (
        .clk   (clk),
        .rst_n (rst_n),
        .desel (sram_ce_n),
        .due   (due)
    );

    // Outputs from the registered state.
    always_comb begin
        req_ready = 1'b0;
        sram_ce_n = 1'b1;
        sram_ld_n = 1'b0;
        sram_we_n = 1'b1;
        sram_bw_n = '1;
        sram_addr = seq_addr;
        ph_valid  = 1'b0;
        ph_data   = wdata_q[beat_q*DW +: DW];
        unique case (state_q)
            ST_IDLE: begin
                req_ready = !due;
            end
            ST_ACCESS: begin
                sram_ce_n = 1'b0;
                sram_ld_n = (beat_q != '0);
                sram_we_n = !wr_q;
                if (wr_q) begin
                    sram_bw_n = ~be_q[beat_q*NB +: NB];
                end
                ph_valid = 1'b1;
            end
            ST_FORCE: begin
                req_ready = 1'b0;
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

    sbc_bus_pipe #(.DW(DW)) u_bus_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph_valid (ph_valid),
        .ph_write (wr_q),
        .ph_data  (ph_data),
        .dq_in    (sram_dq_in),
        .dq_out   (sram_dq_out),
        .dq_oe    (sram_dq_oe),
        .oe_n     (sram_oe_n),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // R2: a burst, once started, keeps issuing advance beats until its last.
    a_r2_burst_contig: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ACCESS) && (beat_q != len_q)) |=> (!sram_ce_n && sram_ld_n));

    // R9: the bus is quiet two clocks after any deselected cycle.
    a_r9_quiet_after_desel: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sram_ce_n, 2) |-> (!sram_dq_oe && sram_oe_n));

    // R12: a due deselect starts right after the final beat, with ready held low.
    a_r12_force_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && due) |=> ((state_q == ST_FORCE) && !req_ready));

    // R13: the burst-order strap stays put out of reset.
    a_r13_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(burst_mode));

endmodule

// File: tb/sram_burst_ctrl_test.sv
module sram_burst_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 8;
    localparam int DW   = 32;
    localparam int NB   = DW / 8;
    localparam int MAXB = 8;
    localparam int CW   = $clog2(MAXB);
    localparam int DL   = 60;
    localparam int MEMW = 1 << AW;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 burst_mode = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic                 req_write = 1'b0;
    logic [AW-1:0]        req_addr = '0;
    logic [CW-1:0]        req_len = '0;
    logic [MAXB*DW-1:0]   req_wdata = '0;
    logic [MAXB*NB-1:0]   req_be = '0;
    logic                 rd_valid;
    logic [DW-1:0]        rd_data;
    logic [AW-1:0]        sram_addr;
    logic                 sram_ld_n, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [NB-1:0]        sram_bw_n;
    logic [DW-1:0]        sram_dq_out;
    logic [DW-1:0]        sram_dq_in;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_burst_ctrl #(.AW(AW), .DW(DW), .MAX_BEATS(MAXB), .DEADLINE(DL)) uut (
        .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata), .req_be(req_be),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .sram_addr(sram_addr), .sram_ld_n(sram_ld_n), .sram_ce_n(sram_ce_n),
        .sram_we_n(sram_we_n), .sram_bw_n(sram_bw_n), .sram_oe_n(sram_oe_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural memory with a two-deep phase pipe, sampled from the pins.
    logic [DW-1:0] mem [MEMW];
    logic [DW-1:0] shadow [MEMW];
    logic          p1v, p1w, p2v, p2w;
    logic [AW-1:0] p1a, p2a;
    logic [NB-1:0] p1b, p2b;

    always @(posedge clk) begin
        if (!rst_n) begin
            p1v <= 1'b0; p1w <= 1'b0; p2v <= 1'b0; p2w <= 1'b0;
            p1a <= '0; p2a <= '0; p1b <= '1; p2b <= '1;
        end else begin
            if (p2v && p2w && sram_dq_oe) begin
                for (int j = 0; j < NB; j++) begin
                    if (!p2b[j]) mem[p2a][8*j +: 8] <= sram_dq_out[8*j +: 8];
                end
            end
            p2v <= p1v; p2w <= p1w; p2a <= p1a; p2b <= p1b;
            p1v <= !sram_ce_n; p1w <= !sram_we_n; p1a <= sram_addr; p1b <= sram_bw_n;
        end
    end

    assign sram_dq_in = (p2v && !p2w) ? mem[p2a] : 32'hDEAD_BEEF;

    typedef struct {
        logic [AW-1:0] a;
        bit            ld;
        bit            we;
        logic [NB-1:0] bw;
        int            k;
    } beat_t;

    beat_t         eq[$];
    logic [DW-1:0] wq[$];
    logic [DW-1:0] rq[$];

    int cyc, last_ok, run, n_forced;
    bit forced;

    // Per-cycle comparison against the reference model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cyc++;
            // Data-phase bus behaviour.
            if (p2v && p2w) begin
                chk(sram_dq_oe && sram_oe_n, "R7", "write phase drive/oe", {sram_dq_oe, sram_oe_n}, 2'b11);
                if (wq.size() > 0) chk(sram_dq_out == wq[0], "R7", "write data", sram_dq_out, wq[0]);
                else chk(1'b0, "R7", "unexpected write phase", 1, 0);
                if (wq.size() > 0) void'(wq.pop_front());
            end else if (p2v) begin
                chk(!sram_dq_oe && !sram_oe_n, "R8", "read phase drive/oe", {sram_dq_oe, sram_oe_n}, 2'b00);
            end else begin
                chk(!sram_dq_oe && sram_oe_n, "R9", "quiet bus", {sram_dq_oe, sram_oe_n}, 2'b01);
            end
            // Address phases.
            if (!sram_ce_n) begin
                if (eq.size() == 0) begin
                    chk(1'b0, "R2", "unexpected address phase", 1, 0);
                end else begin
                    beat_t e;
                    string tag;
                    e = eq.pop_front();
                    tag = (e.k >= 4) ? "R5" : (burst_mode ? "R4" : "R3");
                    chk(sram_addr == e.a, tag, "beat address", sram_addr, e.a);
                    chk(sram_ld_n == e.ld && sram_we_n == e.we, "R2", "load/we", {sram_ld_n, sram_we_n}, {e.ld, e.we});
                    chk(sram_bw_n == e.bw, "R6", "byte enables", sram_bw_n, e.bw);
                end
            end else begin
                chk(sram_ld_n == 1'b0, "R10", "load low when deselected", sram_ld_n, 0);
                if (eq.size() > 0) chk(eq[0].k == 0, "R12", "burst split", eq[0].k, 0);
            end
            // Read data.
            if (rd_valid) begin
                if (rq.size() > 0) begin
                    chk(rd_data == rq[0], "R8", "read data", rd_data, rq[0]);
                    void'(rq.pop_front());
                end else begin
                    chk(1'b0, "R8", "unexpected rd_valid", 1, 0);
                end
            end
            // Deselect intervals.
            if (sram_ce_n) begin
                run++;
                if (!req_ready) forced = 1'b1;
                if (run >= 4) last_ok = cyc;
            end else begin
                if (forced) begin
                    chk(run >= 4, "R12", "forced deselect length", run, 4);
                    n_forced++;
                end
                run = 0;
                forced = 1'b0;
            end
            chk(cyc - last_ok <= DL, "R11", "deselect interval", cyc - last_ok, DL);
        end
    end

    function automatic int low_bits(input int s, input int k, input bit ilv);
        if (ilv) return (s ^ (k % 4)) & 3;
        return (s + k) % 4;
    endfunction

    task automatic send(input bit wr, input int start, input int len, input int seed);
        logic [NB-1:0] be;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(start);
        req_len   = CW'(len);
        for (int k = 0; k < MAXB; k++) begin
            req_wdata[k*DW +: DW] = DW'(32'h1000_0000 * (seed % 15) + 32'h0101 * (k + 1) + seed);
            be = NB'((k + seed) % 16);
            if (k == 0) be = '1;
            req_be[k*NB +: NB] = be;
        end
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        for (int k = 0; k <= len; k++) begin
            beat_t e;
            e.a  = AW'((start & ~3) | low_bits(start & 3, k, burst_mode));
            e.ld = (k != 0);
            e.we = !wr;
            e.bw = wr ? ~req_be[k*NB +: NB] : '1;
            e.k  = k;
            eq.push_back(e);
            if (wr) begin
                wq.push_back(req_wdata[k*DW +: DW]);
                for (int j = 0; j < NB; j++)
                    if (req_be[k*NB + j]) shadow[e.a][8*j +: 8] = req_wdata[k*DW + 8*j +: 8];
            end else begin
                rq.push_back(shadow[e.a]);
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_reset(input bit mode);
        @(negedge clk);
        rst_n = 1'b0;
        burst_mode = mode;
        repeat (4) @(negedge clk);
        // R1: state while reset is held.
        chk(sram_ce_n && !sram_ld_n && sram_oe_n && !sram_dq_oe && !rd_valid && req_ready,
            "R1", "reset outputs",
            {sram_ce_n, sram_ld_n, sram_oe_n, sram_dq_oe, rd_valid, req_ready}, 6'b101001);
        cyc = 0; last_ok = 0; run = 0; forced = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(sram_ce_n && req_ready && !sram_dq_oe, "R1", "after release",
            {sram_ce_n, req_ready, sram_dq_oe}, 3'b110);
    endtask

    task automatic pattern_set(input int base);
        send(1, base + 0, 0, 1);                 // single write
        send(0, base + 0, 0, 2);                 // single read
        for (int s = 0; s < 4; s++) begin
            send(1, base + 8 + s, 3, 3 + s);     // four-beat writes, each start
            send(0, base + 8 + s, 3, 0);
        end
        send(1, base + 17, 7, 9);                // wrap past the fourth beat
        send(0, base + 17, 7, 0);
        send(0, base + 16, 5, 0);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < MEMW; i++) begin
            mem[i] = '0;
            shadow[i] = '0;
        end
        n_forced = 0;
        do_reset(1'b0);
        pattern_set(32);
        // Saturating traffic forces deselects.
        for (int i = 0; i < 30; i++) send(i[0], (i * 37) % MEMW, 3 + (i % 2) * 4, i + 5);
        repeat (8) @(negedge clk);
        // Long idle must keep the deadline satisfied by itself.
        repeat (3 * DL) @(negedge clk);
        do_reset(1'b1);
        pattern_set(96);
        for (int i = 0; i < 20; i++) send(!i[0], (i * 53) % MEMW, 3, i + 40);
        repeat (8) @(negedge clk);
        chk(eq.size() == 0 && wq.size() == 0 && rq.size() == 0, "R2", "all beats issued",
            eq.size() + wq.size() + rq.size(), 0);
        chk(n_forced >= 2, "R12", "forced deselects seen", n_forced, 2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
            $finish;
        end
    end

endmodule